// File: doc/BRIEF.md
# Integer Compare Flag Generator

This block compares two signed integer operands and turns the result into a
condition-flag word for a host processor. Each operand is one 64-bit register
entry. A width select chooses how much of each entry takes part. In narrow
mode only the low 32 bits of each operand are used. In wide mode all 64 bits
are used.

The block forms the difference first operand minus second operand at the
selected width. From the sign bits of the two operands and of the difference
it derives four flags: negative, zero, carry and overflow. The carry flag is
built from those sign bits, not from an adder carry-out.

The flags are packed into the top nibble of a 32-bit status word. The word is
registered and appears one cycle after a start strobe, together with a one-cycle
valid pulse. It then holds until the next start.

Top module: `cmpf_unit`

## Requirements
- R1: While reset is asserted and after its release, `status` reads all zeros and `status_vld` is low until the first start.
- R2: Every cycle with `start` high produces exactly one `status_vld` pulse in the next cycle. `status_vld` is never high in a cycle that does not follow a start. Back-to-back starts give back-to-back results.
- R3: The difference is `opa - opb` at the selected width. Flag N (status bit 31) is the sign bit of that difference.
- R4: Flag Z (status bit 30) is set exactly when the difference at the selected width is zero.
- R5: Flag C (status bit 29) is set when any of these holds: (a negative and b non-negative), (a negative and difference non-negative), (b non-negative and difference non-negative). Signs are taken at the selected width.
- R6: Flag V (status bit 28) is set when the subtraction overflows as a signed operation. That is: a negative, b non-negative and difference non-negative; or a non-negative, b negative and difference negative.
- R7: Status bits 27:0 are always zero.
- R8: With `wide` = 0, only bits 31:0 of each operand affect the result; bits 63:32 are ignored. With `wide` = 1, all 64 bits are used.
- R9: In a cycle after one without `start`, `status` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe: compare the operands presented in this cycle |
| wide | input | 1 | Width select: 0 = low 32 bits, 1 = full 64 bits |
| opa | input | 64 | First operand (minuend) |
| opb | input | 64 | Second operand (subtrahend) |
| status | output | 32 | Flag word: N, Z, C, V in bits 31..28; zeros below |
| status_vld | output | 1 | One-cycle pulse marking a new status word |

## Verification
The bench targets the signed overflow boundaries at both widths, for example
the most negative value minus one and the most positive value minus minus one.
A swapped or misdecoded overflow term turns up as a wrong V or C bit on these
cases.

Narrow compares are issued with differing upper halves. A design that leaks bits
63:32 into narrow mode would report a nonzero difference where equality is
expected.

Equal operands check that Z comes with C set and N clear. Sign-crossing
operands separate the sign-derived carry from a plain unsigned comparison done
at the wrong width.

Back-to-back starts and idle gaps expose a valid pulse that is lost,
duplicated or stretched. They also expose a status word that drifts while no
start is given.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cmpf_flags_t;

   localparam int unsigned FLAG_CNT = 4;

endpackage

// File: rtl/cmpf_sub.sv
module cmpf_sub #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] diff
);
   // Two's complement difference, carry-out deliberately discarded
   assign diff = a - b;
endmodule

// File: rtl/cmpf_lane.sv
module cmpf_lane
   import cmpf_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   output cmpf_flags_t   flags
);
   localparam int unsigned MSB = W - 1;

   logic [W-1:0] diff;
   logic         a_neg;
   logic         b_neg;
   logic         d_neg;

   cmpf_sub #(.W(W)) u_sub (
      .a    (a),
      .b    (b),
      .diff (diff)
   );

   assign a_neg = a[MSB];
   assign b_neg = b[MSB];
   assign d_neg = diff[MSB];

   always_comb begin
      flags.n = d_neg;
      flags.z = (diff == '0);
      // carry derived from operand and result signs only
      flags.c = (a_neg & ~b_neg) | (a_neg & ~d_neg) | (~b_neg & ~d_neg);
      flags.v = (a_neg & ~b_neg & ~d_neg) | (~a_neg & b_neg & d_neg);
   end
endmodule

// File: rtl/cmpf_unit.sv
module cmpf_unit
   import cmpf_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NARROW_W = 32,
   parameter int unsigned STAT_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wide,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [STAT_W-1:0] status,
   output logic              status_vld
);
   localparam int unsigned FLAG_LSB = STAT_W - FLAG_CNT;

   initial begin
      assert (NARROW_W > 0 && NARROW_W <= DATA_W)
         else $error("cmpf_unit: NARROW_W must lie in 1..DATA_W");
      assert (STAT_W >= FLAG_CNT)
         else $error("cmpf_unit: STAT_W too small for the flag nibble");
   end

   cmpf_flags_t fl_narrow;
   cmpf_flags_t fl_wide;
   cmpf_flags_t fl_sel;
   logic [STAT_W-1:0] word_next;

   cmpf_lane #(.W(NARROW_W)) u_lane_narrow (
      .a     (opa[NARROW_W-1:0]),
      .b     (opb[NARROW_W-1:0]),
      .flags (fl_narrow)
   );

   generate
      if (DATA_W == NARROW_W) begin : g_same_width
         assign fl_wide = fl_narrow;
      end else begin : g_wide_lane
         cmpf_lane #(.W(DATA_W)) u_lane_wide (
            .a     (opa),
            .b     (opb),
            .flags (fl_wide)
         );
      end
   endgenerate

   assign fl_sel = wide ? fl_wide : fl_narrow;

   generate
      if (FLAG_LSB > 0) begin : g_pad
         assign word_next = {fl_sel, {FLAG_LSB{1'b0}}};
      end else begin : g_nopad
         assign word_next = fl_sel;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status     <= '0;
         status_vld <= 1'b0;
      end else begin
         status_vld <= start;
         if (start) begin
            status <= word_next;
         end
      end
   end
endmodule

// File: rtl/cmpf_unit_chk.sv
module cmpf_unit_chk #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NARROW_W = 32,
   parameter int unsigned STAT_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              wide,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [STAT_W-1:0] status,
   input logic              status_vld
);
   localparam int unsigned FLAG_LSB = STAT_W - 4;

   p_vld_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> status_vld);

   p_no_spurious_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !status_vld);

   p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status[FLAG_LSB-1:0] == '0);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(status));

   p_zero_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      status_vld |-> status[STAT_W-2] ==
         ($past(wide) ? ($past(opa) == $past(opb))
                      : ($past(opa[NARROW_W-1:0]) == $past(opb[NARROW_W-1:0]))));

   p_zero_implies_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_vld && status[STAT_W-2]) |-> (status[STAT_W-3] && !status[STAT_W-1] && !status[STAT_W-4]));
endmodule

bind cmpf_unit cmpf_unit_chk #(
   .DATA_W   (DATA_W),
   .NARROW_W (NARROW_W),
   .STAT_W   (STAT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .wide       (wide),
   .opa        (opa),
   .opb        (opb),
   .status     (status),
   .status_vld (status_vld)
);

// File: tb/cmpf_unit_tb_top.sv
module cmpf_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        wide = 1'b0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic [31:0] status;
   logic        status_vld;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] last_status = '0;
   logic        done = 1'b0;

   always #2.5 clk = ~clk;

   cmpf_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .wide       (wide),
      .opa        (opa),
      .opb        (opb),
      .status     (status),
      .status_vld (status_vld)
   );

   function automatic logic [31:0] model(input logic w, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] d;
      logic sa, sb, sr, z, n, c, v;
      if (w) begin
         d  = a - b;
         sa = a[63]; sb = b[63]; sr = d[63];
         z  = (d == 64'd0);
      end else begin
         d  = {32'd0, a[31:0] - b[31:0]};
         sa = a[31]; sb = b[31]; sr = d[31];
         z  = (d[31:0] == 32'd0);
      end
      n = sr;
      v = (sa & ~sb & ~sr) | (~sa & sb & sr);
      c = (sa & ~sb) | (sa & ~sr) | (~sb & ~sr);
      return {n, z, c, v, 28'd0};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: leaves start high; a following issue makes it back-to-back
   task automatic issue(input string tag, input logic w, input logic [63:0] a,
                        input logic [63:0] b, input logic [31:0] exp);
      @(negedge clk);
      wide  = w;
      opa   = a;
      opb   = b;
      start = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
         opa   = {opa[31:0], opa[63:32]} ^ 64'h5A5A_0F0F_3C3C_9696;
         opb   = ~opb;
         wide  = ~wide;
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (status_vld) begin
               if (exp_q.size() == 0) begin
                  checks++; errors++;
                  $display("FAIL R2: actual status_vld 1 expected 0 (no start pending)");
               end else begin
                  string t;
                  t = tag_q.pop_front();
                  chk(t, status, exp_q.pop_front());
               end
               last_status = status;
            end else begin
               chk("R9 hold", status, last_status);
               if (exp_q.size() != 0) begin
                  checks++; errors++;
                  $display("FAIL R2: actual status_vld 0 expected 1");
                  void'(exp_q.pop_front());
                  void'(tag_q.pop_front());
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset status", status, 32'd0);
      chk("R1 reset vld", {31'd0, status_vld}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {status[31:1], status_vld}, 32'd0);

      // hand-worked values
      issue("R4 equal narrow", 1'b0, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0007, 32'h6000_0000);
      idle(1);
      issue("R6 narrow minint-1", 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 32'h3000_0000);
      idle(2);
      issue("R3 narrow 0-1", 1'b0, 64'd0, 64'h0000_0000_0000_0001, 32'h8000_0000);
      idle(1);
      issue("R6 narrow maxint-(-1)", 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 32'h9000_0000);
      idle(1);
      issue("R5 narrow neg-pos", 1'b0, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_0000_0001, 32'hA000_0000);
      idle(1);
      issue("R8 narrow ignores upper", 1'b0, 64'hDEAD_BEEF_1234_5678, 64'h0BAD_F00D_1234_5678, 32'h6000_0000);
      idle(1);
      issue("R8 wide uses upper", 1'b1, 64'hDEAD_BEEF_1234_5678, 64'hDEAD_BEEF_1234_5678, 32'h6000_0000);
      idle(1);
      issue("R6 wide minint-1", 1'b1, 64'h8000_0000_0000_0000, 64'd1, 32'h3000_0000);
      idle(1);
      issue("R3 wide 5-6", 1'b1, 64'd5, 64'd6, 32'h8000_0000);
      idle(1);
      issue("R8 wide upper differs", 1'b1, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000, 32'h2000_0000);
      // back-to-back starts
      issue("R2 b2b first", 1'b1, 64'd10, 64'd3, 32'h2000_0000);
      issue("R2 b2b second", 1'b0, 64'd3, 64'd10, 32'h8000_0000);
      issue("R7 b2b third", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h6000_0000);
      idle(3);

      // swept patterns checked against the requirement model
      for (int i = 0; i < 200; i++) begin
         logic [63:0] a, b;
         logic w;
         a = {32'(i * 32'h9E37_79B9), 32'(i * 32'h85EB_CA6B)};
         b = {32'(i * 32'hC2B2_AE35), 32'((i ^ 7) * 32'h27D4_EB2F)};
         if (i % 5 == 0) b = a ^ 64'hFFFF_FFFF_0000_0000;
         w = i[0];
         issue("R3 R5 R6 sweep", w, a, b, model(w, a, b));
         if (i % 3 == 0) idle(1);
      end
      idle(4);

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule